// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction in the execute stage of a five-stage in-order pipeline, where the operand value should come from. The choices are the value read from the register file during decode, the ALU result waiting in the memory stage, or the value waiting to be written back. It compares the two source register numbers of the executing instruction against the destinations of the two older instructions still in flight. It emits a 2-bit select code per operand and the chosen operand value itself. A register write from a newer instruction always wins over one from an older instruction, and register 0 is never bypassed.

A second, smaller path handles a load followed at once by a store of the loaded register. The store is then in the memory stage while the load's data sits in write-back, so the data written to memory is taken from the write-back value instead of the store data carried down the pipe. The rt-side operand also leaves the block as the store data for the executing instruction, so a store whose data register comes from the instruction just ahead of it receives the bypassed value.

All logic is combinational. The block holds no state, so there are no states or transitions. The pipeline registers, register file, ALU and memories sit around it.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (memory-stage result) when `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals `ex_src_a_idx`.
- R2: `sel_a` is 2'b01 (write-back value) when the R1 condition is false, `wb_wr_en` is 1, `wb_dst_idx` is nonzero and `wb_dst_idx` equals `ex_src_a_idx`.
- R3: `sel_b` follows the R1 and R2 rules with `ex_src_b_idx` in place of `ex_src_a_idx`.
- R4: With no match, the select is 2'b00 and the operand equals the register-file value (`rf_a_val` or `rf_b_val`).
- R5: When both stages write the same nonzero source register, the select is 2'b10 and the memory-stage result is used.
- R6: A source index of 0 always gives select 2'b00, whatever the stage destinations are.
- R7: `opnd_a` and `opnd_b` equal `rf_*_val` for select 2'b00, `wb_val` for 2'b01, and `mem_alu_val` for 2'b10.
- R8: `ex_store_data` always equals `opnd_b`.
- R9: `dmem_wdata` equals `wb_val` when `mem_is_store` is 1, `wb_wr_en` is 1, `wb_dst_idx` is nonzero and `wb_dst_idx` equals `mem_st_idx`. Otherwise it equals `mem_st_data`.
- R10: A stage whose write flag is 0 never causes a bypass, even when its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | RW (5) | First source register number of the executing instruction |
| ex_src_b_idx | input | RW (5) | Second source register number of the executing instruction |
| mem_dst_idx | input | RW (5) | Destination register number of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | RW (5) | Destination register number of the write-back instruction |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| rf_a_val | input | DW (32) | Register-file value for the first source |
| rf_b_val | input | DW (32) | Register-file value for the second source |
| mem_alu_val | input | DW (32) | ALU result held in the memory stage |
| wb_val | input | DW (32) | Value about to be written back |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_idx | input | RW (5) | Data register number of the memory-stage store |
| mem_st_data | input | DW (32) | Store data carried into the memory stage |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DW (32) | Chosen first ALU operand |
| opnd_b | output | DW (32) | Chosen second ALU operand |
| ex_store_data | output | DW (32) | Store data passed on to the memory stage |
| dmem_wdata | output | DW (32) | Write data presented to data memory |

## Verification
The bench builds the block with its default widths: 5-bit register numbers and 32-bit data. It first replays a short dependent instruction sequence in which every register holds its number plus 100. A subtract result must reach the next instruction from the memory stage and the one after from write-back. In the random phase, register numbers are drawn from 0 to 3, so matches in both stages, double matches and register-0 matches occur often. Values of about 32 bits make it unlikely that a wrong source selection goes unnoticed.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE   = 2'b00,
        SRC_WRITEBACK = 2'b01,
        SRC_MEMSTAGE  = 2'b10
    } opsrc_e;

    localparam int NUM_OPND = 2;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_idx,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_we,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_we,
    output opsrc_e        sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_dst != '0) && (mem_dst == src_idx);
        wb_hit  = wb_we  && (wb_dst  != '0) && (wb_dst  == src_idx);
        if (mem_hit)
            sel = SRC_MEMSTAGE;
        else if (wb_hit)
            sel = SRC_WRITEBACK;
        else
            sel = SRC_REGFILE;
    end
endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  opsrc_e        sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] mem_val,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_MEMSTAGE:  y = mem_val;
            SRC_WRITEBACK: y = wb_val;
            default:       y = rf_val;
        endcase
    end
endmodule

// File: rtl/st_bypass.sv
module st_bypass #(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input  logic          is_store,
    input  logic [RW-1:0] st_idx,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_we,
    input  logic [DW-1:0] carried,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] wdata
);
    logic take_wb;

    always_comb begin
        take_wb = is_store && wb_we && (wb_dst != '0) && (wb_dst == st_idx);
        wdata   = take_wb ? wb_val : carried;
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input  logic [RW-1:0] ex_src_a_idx,
    input  logic [RW-1:0] ex_src_b_idx,
    input  logic [RW-1:0] mem_dst_idx,
    input  logic          mem_wr_en,
    input  logic [RW-1:0] wb_dst_idx,
    input  logic          wb_wr_en,
    input  logic [DW-1:0] rf_a_val,
    input  logic [DW-1:0] rf_b_val,
    input  logic [DW-1:0] mem_alu_val,
    input  logic [DW-1:0] wb_val,
    input  logic          mem_is_store,
    input  logic [RW-1:0] mem_st_idx,
    input  logic [DW-1:0] mem_st_data,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b,
    output logic [DW-1:0] ex_store_data,
    output logic [DW-1:0] dmem_wdata
);
    logic [RW-1:0] src_arr [NUM_OPND];
    logic [DW-1:0] rf_arr  [NUM_OPND];
    logic [DW-1:0] op_arr  [NUM_OPND];
    opsrc_e        sel_arr [NUM_OPND];

    assign src_arr[0] = ex_src_a_idx;
    assign src_arr[1] = ex_src_b_idx;
    assign rf_arr[0]  = rf_a_val;
    assign rf_arr[1]  = rf_b_val;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_pick #(.RW(RW)) u_pick (
            .src_idx (src_arr[g]),
            .mem_dst (mem_dst_idx),
            .mem_we  (mem_wr_en),
            .wb_dst  (wb_dst_idx),
            .wb_we   (wb_wr_en),
            .sel     (sel_arr[g])
        );
        fwd_mux3 #(.DW(DW)) u_mux (
            .sel     (sel_arr[g]),
            .rf_val  (rf_arr[g]),
            .wb_val  (wb_val),
            .mem_val (mem_alu_val),
            .y       (op_arr[g])
        );
    end

    st_bypass #(.RW(RW), .DW(DW)) u_st (
        .is_store (mem_is_store),
        .st_idx   (mem_st_idx),
        .wb_dst   (wb_dst_idx),
        .wb_we    (wb_wr_en),
        .carried  (mem_st_data),
        .wb_val   (wb_val),
        .wdata    (dmem_wdata)
    );

    assign sel_a         = sel_arr[0];
    assign sel_b         = sel_arr[1];
    assign opnd_a        = op_arr[0];
    assign opnd_b        = op_arr[1];
    assign ex_store_data = op_arr[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input logic [RW-1:0] ex_src_a_idx,
    input logic [RW-1:0] ex_src_b_idx,
    input logic [RW-1:0] mem_dst_idx,
    input logic          mem_wr_en,
    input logic [RW-1:0] wb_dst_idx,
    input logic          wb_wr_en,
    input logic [DW-1:0] rf_a_val,
    input logic [DW-1:0] mem_alu_val,
    input logic [DW-1:0] wb_val,
    input logic          mem_is_store,
    input logic [RW-1:0] mem_st_idx,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic [DW-1:0] ex_store_data,
    input logic [DW-1:0] dmem_wdata
);
    always_comb begin
        // R6: register zero is never bypassed
        if (ex_src_a_idx == '0)
            assert_zero_src_R6: assert (sel_a == 2'b00);
        // R5: newer stage wins on a double match
        if (mem_wr_en && wb_wr_en && mem_dst_idx == wb_dst_idx &&
            mem_dst_idx == ex_src_b_idx && ex_src_b_idx != '0)
            assert_newest_wins_R5: assert (sel_b == 2'b10);
        // R10: a stage with its write flag clear cannot be the source
        if (!mem_wr_en)
            assert_no_mem_when_idle_R10: assert (sel_a != 2'b10 && sel_b != 2'b10);
        // R7: the operand follows the select
        if (sel_a == 2'b10)
            assert_opnd_from_mem_R7: assert (opnd_a == mem_alu_val);
        if (sel_a == 2'b00)
            assert_opnd_from_rf_R4: assert (opnd_a == rf_a_val);
        // R8: store data for the next stage is the B operand
        assert_store_data_R8: assert (ex_store_data == opnd_b);
        // R9: load-to-store bypass in the memory stage
        if (mem_is_store && wb_wr_en && wb_dst_idx != '0 && wb_dst_idx == mem_st_idx)
            assert_load_store_R9: assert (dmem_wdata == wb_val);
    end
endmodule

bind fwd_unit fwd_unit_chk #(.RW(RW), .DW(DW)) u_chk (
    .ex_src_a_idx  (ex_src_a_idx),
    .ex_src_b_idx  (ex_src_b_idx),
    .mem_dst_idx   (mem_dst_idx),
    .mem_wr_en     (mem_wr_en),
    .wb_dst_idx    (wb_dst_idx),
    .wb_wr_en      (wb_wr_en),
    .rf_a_val      (rf_a_val),
    .mem_alu_val   (mem_alu_val),
    .wb_val        (wb_val),
    .mem_is_store  (mem_is_store),
    .mem_st_idx    (mem_st_idx),
    .sel_a         (sel_a),
    .sel_b         (sel_b),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .ex_store_data (ex_store_data),
    .dmem_wdata    (dmem_wdata)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    int   checks = 0;
    int   failures = 0;

    logic [RW-1:0] src_a = '0, src_b = '0, mdst = '0, wdst = '0, sidx = '0;
    logic          mwe = 1'b0, wwe = 1'b0, is_st = 1'b0;
    logic [DW-1:0] rfa = '0, rfb = '0, malu = '0, wbv = '0, sdat = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b, ex_sd, dmem_wd;

    always #10 clk = ~clk;

    fwd_unit #(.RW(RW), .DW(DW)) uut (
        .ex_src_a_idx (src_a), .ex_src_b_idx (src_b),
        .mem_dst_idx (mdst), .mem_wr_en (mwe),
        .wb_dst_idx (wdst), .wb_wr_en (wwe),
        .rf_a_val (rfa), .rf_b_val (rfb),
        .mem_alu_val (malu), .wb_val (wbv),
        .mem_is_store (is_st), .mem_st_idx (sidx), .mem_st_data (sdat),
        .sel_a (sel_a), .sel_b (sel_b), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .ex_store_data (ex_sd), .dmem_wdata (dmem_wd)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: walk the in-flight producers newest first.
    function automatic logic [1:0] model_sel(input logic [RW-1:0] s);
        logic [RW-1:0] dq[$];
        bit            wq[$];
        logic [1:0]    cq[$];
        dq = '{mdst, wdst};
        wq = '{mwe, wwe};
        cq = '{2'b10, 2'b01};
        if (s == 0) return 2'b00;
        for (int k = 0; k < 2; k++)
            if (wq[k] && dq[k] == s) return cq[k];
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [RW-1:0] s);
        if (s == 0) return "R6";
        if (mwe && wwe && mdst == s && wdst == s) return "R5";
        if (mwe && mdst == s) return "R1";
        if (wwe && wdst == s) return "R2";
        if (mdst == s || wdst == s) return "R10";
        return "R4";
    endfunction

    function automatic logic [DW-1:0] pick(input logic [1:0] c, input logic [DW-1:0] rf);
        if (c == 2'b10) return malu;
        if (c == 2'b01) return wbv;
        return rf;
    endfunction

    // Compare every cycle, away from the driving edge.
    always @(negedge clk) begin
        if (run) begin
            logic [1:0] ea, eb;
            ea = model_sel(src_a);
            eb = model_sel(src_b);
            chk({sel_tag(src_a), " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
            chk({"R3 sel_b ", sel_tag(src_b)}, {30'd0, sel_b}, {30'd0, eb});
            chk("R7 opnd_a", opnd_a, pick(ea, rfa));
            chk("R7 opnd_b", opnd_b, pick(eb, rfb));
            chk("R8 ex_store_data", ex_sd, pick(eb, rfb));
            chk("R9 dmem_wdata", dmem_wd,
                (is_st && wwe && wdst != 0 && wdst == sidx) ? wbv : sdat);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Architectural register value: number plus 100.
    function automatic logic [DW-1:0] rv(input int n);
        return DW'(n + 100);
    endfunction

    initial begin : watchdog
        #(20 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] r_sub, r_and, r_or;
        r_sub = rv(1) - rv(3);
        r_and = r_sub & rv(5);
        r_or  = rv(6) | r_sub;
        step();
        rst_n = 1'b1;
        step();
        // Reset state: idle inputs select the register file (R4)
        chk("R4 idle sel_a", {30'd0, sel_a}, 32'd0);
        chk("R4 idle sel_b", {30'd0, sel_b}, 32'd0);
        run = 1'b1;

        // Cycle 4: 'and $12,$2,$5' in EX, 'sub $2' in MEM
        src_a = 2; src_b = 5; rfa = rv(2); rfb = rv(5);
        mdst = 2; mwe = 1; malu = r_sub; wdst = 0; wwe = 0; wbv = 0;
        is_st = 0; sidx = 0; sdat = 0;
        #1;
        chk("R1 cycle4 sel_a from memory stage", {30'd0, sel_a}, 32'd2);
        chk("R7 cycle4 opnd_a", opnd_a, r_sub);
        step();
        // Cycle 5: 'or $13,$6,$2' in EX, 'and $12' in MEM, 'sub $2' in WB
        src_a = 6; src_b = 2; rfa = rv(6); rfb = rv(2);
        mdst = 12; mwe = 1; malu = r_and; wdst = 2; wwe = 1; wbv = r_sub;
        #1;
        chk("R3 cycle5 sel_b from write-back", {30'd0, sel_b}, 32'd1);
        chk("R7 cycle5 opnd_b", opnd_b, r_sub);
        step();
        // Cycle 6: 'add $14,$2,$2' reads the updated register file
        src_a = 2; src_b = 2; rfa = r_sub; rfb = r_sub;
        mdst = 13; malu = r_or; wdst = 12; wbv = r_and;
        #1;
        chk("R4 cycle6 opnd_a", opnd_a, r_sub);
        step();
        // Cycle 7: 'sw $15,100($2)' store data comes from the register file
        src_a = 2; src_b = 15; rfa = r_sub; rfb = rv(15);
        mdst = 14; malu = r_sub + r_sub; wdst = 13; wbv = r_or;
        #1;
        chk("R8 cycle7 store data", ex_sd, rv(15));
        step();

        // Double match: newest wins (R5)
        src_a = 7; src_b = 7; mdst = 7; wdst = 7; mwe = 1; wwe = 1;
        malu = 32'hAAAA0001; wbv = 32'h5555_0002;
        #1;
        chk("R5 double match opnd_a", opnd_a, 32'hAAAA0001);
        step();
        // Register zero (R6)
        src_a = 0; src_b = 0; mdst = 0; wdst = 0; rfa = 32'h1234; rfb = 32'h5678;
        #1;
        chk("R6 zero opnd_a", opnd_a, 32'h1234);
        chk("R6 zero opnd_b", opnd_b, 32'h5678);
        step();
        // Write flags clear (R10)
        src_a = 9; src_b = 9; mdst = 9; wdst = 9; mwe = 0; wwe = 0;
        rfa = 32'hC0DE; rfb = 32'hBEEF;
        #1;
        chk("R10 disabled stages opnd_b", opnd_b, 32'hBEEF);
        step();
        // Load then store of the loaded register (R9)
        is_st = 1; sidx = 4; wdst = 4; wwe = 1; wbv = 32'hFEED_0004; sdat = 32'h0BAD;
        #1;
        chk("R9 load-store bypass", dmem_wd, 32'hFEED_0004);
        step();
        wwe = 0;
        #1;
        chk("R9 no bypass when write-back idle", dmem_wd, 32'h0BAD);
        step();

        // Random phase with small register numbers
        for (int i = 0; i < 400; i++) begin
            src_a = RW'($urandom % 4); src_b = RW'($urandom % 4);
            mdst  = RW'($urandom % 4); wdst  = RW'($urandom % 4);
            sidx  = RW'($urandom % 4);
            mwe = 1'($urandom); wwe = 1'($urandom); is_st = 1'($urandom);
            rfa = $urandom; rfb = $urandom; malu = $urandom;
            wbv = $urandom; sdat = $urandom;
            step();
        end
        run = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule